// File: doc/BRIEF.md
# Serial Strobed Register Slave

This block is the device end of a four-wire serial register port: a serial clock, a data input, a data output and an active-low strobe. There is no framing by chip select. Every clock pulse with the strobe high shifts one bit into a frame register. A clock pulse taken while the strobe is low carries the command bit. At that pulse the block decodes the bits it holds as either a write or a read of a small register file.

A write frame is 32 data bits, then 8 address bits, then a command bit of 1. A read frame is 8 address bits and a command bit of 0. After a read command, the next 32 clock pulses return the selected register on the data output. Every field moves most significant bit first. The register file has:
- a mode register and a multiplexer register, both read/write;
- a read-only view of a 32-bit switch input;
- a read-only version constant;
- a reset register. Writing a 1 to it raises a system reset request for a fixed number of system clocks, after which the register clears itself.

The three serial inputs come from pins. They are brought into the system clock domain through two-flop synchronizers, and their edges are found there. The serial clock must therefore run well below the system clock.

Top module: `ssr_slave`

## Requirements
- R1: After reset, the data output is high, the reset request is low, and the mode, multiplexer and reset registers read as zero.
- R2: A write frame sets the register at that address. The frame is 32 data bits, then 8 address bits, then a command bit of 1 clocked with the strobe low, all MSB first. The mode register is at 0x00.
- R3: A read frame returns the register on the data output over the next 32 serial clock pulses, MSB first. The frame is 8 address bits and a command bit of 0 clocked with the strobe low. Each bit is valid before the rising serial clock edge that reads it, and the output changes only after a serial clock edge.
- R4: The multiplexer register at 0x02 is read/write and independent of the mode register.
- R5: The register at 0x08 returns the live switch input. Writes to it have no effect.
- R6: The register at 0xFF returns the VERSION parameter. Writes to it have no effect.
- R7: Reads of addresses other than 0x00, 0x02, 0x08, 0x80 and 0xFF return zero. Writes to those addresses change no register.
- R8: A write to 0x80 with data bit 0 set raises the reset request for exactly RST_CYCLES system clocks. The register then reads as zero again.
- R9: A write to 0x80 with data bit 0 clear raises no reset request. No reset request rises without such a write.
- R10: The data output is high whenever no read is in progress, including after the 32nd bit of a read.
- R11: Only the last 40 bits shifted in before the command bit count. Earlier bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Serial data from the host |
| stb_ni | input | 1 | Command strobe, active low |
| sdo_o | output | 1 | Serial data to the host, idles high |
| sw_i | input | DATA_W | Switch input, read through address 0x08 |
| reset_req_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with RST_CYCLES set to 5, so the measured pulse length can be compared to the cycle. VERSION is set to a pattern with both end bits high, so an error in bit order or a missed first bit shows up in the returned word. The serial clock half period is four system clocks. This is just long enough to cover the synchronizer and edge-detect latency, so the first-bit-valid timing of a read is exercised at its tightest margin. A leading run of stray bits before one write frame exercises the 40-bit frame window.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADR_MODE = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_MUX  = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_SW   = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_RST  = 8'h80;
  localparam logic [ADDR_W-1:0] ADR_VER  = 8'hFF;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {2{RST_VAL}};
    else         ff_q <= {ff_q[0], d_i};
  end

  assign q_o = ff_q[1];
endmodule

// File: rtl/ssr_serial_if.sv
module ssr_serial_if
  import ssr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_s_i,
  input  logic              sdi_s_i,
  input  logic              stb_ns_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              sck_rise_o,
  output logic              sck_fall_o,
  output logic              rd_busy_o,
  output logic              sdo_o
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int LEFT_W  = $clog2(DATA_W + 1);

  logic               sck_d_q;
  logic [FRAME_W-1:0] frame_q;
  logic [DATA_W-1:0]  out_q;
  logic [LEFT_W-1:0]  left_q;
  logic               busy_q;
  logic               pend_q;
  logic               cmd_hit;

  assign sck_rise_o = sck_s_i & ~sck_d_q;
  assign sck_fall_o = ~sck_s_i & sck_d_q;
  assign cmd_hit    = sck_rise_o & ~stb_ns_i;
  assign wr_en_o    = cmd_hit & sdi_s_i;
  assign addr_o     = frame_q[ADDR_W-1:0];
  assign wdata_o    = frame_q[FRAME_W-1:ADDR_W];
  assign rd_busy_o  = busy_q;
  assign sdo_o      = busy_q ? out_q[DATA_W-1] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q <= 1'b0;
      frame_q <= '0;
      out_q   <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      sck_d_q <= sck_s_i;
      if (sck_rise_o) begin
        if (stb_ns_i) begin
          frame_q <= {frame_q[FRAME_W-2:0], sdi_s_i};
          if (busy_q) pend_q <= 1'b1;
        end else if (!sdi_s_i) begin
          // load read word; MSB is presented at once
          out_q  <= rdata_i;
          busy_q <= 1'b1;
          left_q <= LEFT_W'(DATA_W);
          pend_q <= 1'b0;
        end
      end else if (sck_fall_o && pend_q) begin
        // advance only after the host has sampled on a rising edge
        out_q  <= {out_q[DATA_W-2:0], 1'b1};
        pend_q <= 1'b0;
        left_q <= left_q - 1'b1;
        if (left_q == LEFT_W'(1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssr_regfile.sv
module ssr_regfile
  import ssr_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                RST_CYCLES = 16,
  parameter logic [DATA_W-1:0] VERSION    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reset_req_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [DATA_W-1:0] mode_q, mux_q;
  logic              rst_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      mux_q  <= '0;
      rst_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (wr_en_i && addr_i == ADR_MODE) mode_q <= wdata_i;
      if (wr_en_i && addr_i == ADR_MUX)  mux_q  <= wdata_i;
      if (rst_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(RST_CYCLES - 1)) rst_q <= 1'b0;
      end else if (wr_en_i && addr_i == ADR_RST && wdata_i[0]) begin
        rst_q <= 1'b1;
        cnt_q <= '0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      ADR_MODE: rdata_o = mode_q;
      ADR_MUX:  rdata_o = mux_q;
      ADR_SW:   rdata_o = sw_i;
      ADR_RST:  rdata_o = {{(DATA_W-1){1'b0}}, rst_q};
      ADR_VER:  rdata_o = VERSION;
      default:  rdata_o = '0;
    endcase
  end

  assign reset_req_o = rst_q;
endmodule

// File: rtl/ssr_slave.sv
module ssr_slave
  import ssr_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                RST_CYCLES = 16,
  parameter logic [DATA_W-1:0] VERSION    = 32'h0001_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              stb_ni,
  output logic              sdo_o,
  input  logic [DATA_W-1:0] sw_i,
  output logic              reset_req_o
);
  logic              sck_s, sdi_s, stb_ns;
  logic              wr_en, sck_rise, sck_fall, rd_busy;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata, rdata;

  ssr_sync #(.RST_VAL(1'b0)) u_sync_sck (.clk_i, .rst_ni, .d_i(sck_i),  .q_o(sck_s));
  ssr_sync #(.RST_VAL(1'b0)) u_sync_sdi (.clk_i, .rst_ni, .d_i(sdi_i),  .q_o(sdi_s));
  ssr_sync #(.RST_VAL(1'b1)) u_sync_stb (.clk_i, .rst_ni, .d_i(stb_ni), .q_o(stb_ns));

  ssr_serial_if #(.DATA_W(DATA_W)) u_serial (
    .clk_i, .rst_ni,
    .sck_s_i(sck_s), .sdi_s_i(sdi_s), .stb_ns_i(stb_ns),
    .rdata_i(rdata),
    .wr_en_o(wr_en), .addr_o(cmd_addr), .wdata_o(cmd_wdata),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .rd_busy_o(rd_busy), .sdo_o(sdo_o)
  );

  ssr_regfile #(.DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES), .VERSION(VERSION)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .addr_i(cmd_addr), .wdata_i(cmd_wdata),
    .sw_i, .rdata_o(rdata), .reset_req_o
  );
endmodule

// File: rtl/ssr_slave_chk.sv
module ssr_slave_chk
  import ssr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sdo_o,
  input logic              reset_req_o,
  input logic              rd_busy,
  input logic              sck_rise,
  input logic              sck_fall,
  input logic              wr_en,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_wdata
);
  localparam int RUN_W = $clog2(RST_CYCLES + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (reset_req_o) run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  assert_sdo_idle_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_busy |-> sdo_o);

  assert_sdo_moves_on_sck_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $past(sck_rise || sck_fall));

  assert_pulse_not_long_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> run_q < RUN_W'(RST_CYCLES));

  assert_pulse_exact_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reset_req_o) |-> run_q == RUN_W'(RST_CYCLES));

  assert_pulse_needs_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_req_o) |-> $past(wr_en && cmd_addr == ADR_RST && cmd_wdata[0]));
endmodule

bind ssr_slave ssr_slave_chk #(.DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sdo_o(sdo_o), .reset_req_o(reset_req_o),
  .rd_busy(rd_busy), .sck_rise(sck_rise), .sck_fall(sck_fall),
  .wr_en(wr_en), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
);

// File: tb/ssr_slave_tb_top.sv
module ssr_slave_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          HALF       = 4;
  localparam int          RST_CYC    = 5;
  localparam logic [31:0] VER        = 32'h8A5C_3017;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, sdi = 1'b0, stb_n = 1'b1;
  logic        sdo, rreq;
  logic [31:0] sw = 32'h0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ssr_slave #(.DATA_W(32), .RST_CYCLES(RST_CYC), .VERSION(VER)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi), .stb_ni(stb_n),
    .sdo_o(sdo), .sw_i(sw), .reset_req_o(rreq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    wait_clk(HALF); sck = 1'b1;
    wait_clk(HALF); sck = 1'b0;
  endtask

  task automatic cmd_bit(input logic b);
    sdi = b; stb_n = 1'b0;
    wait_clk(HALF); sck = 1'b1;
    wait_clk(HALF); sck = 1'b0;
    wait_clk(HALF); stb_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    for (int i = 31; i >= 0; i--) send_bit(d[i]);
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
    cmd_bit(1'b1);
    wait_clk(4);
  endtask

  // driver: pushes expectation, monitor compares bits as they come out
  task automatic do_read(input logic [7:0] a, input logic [31:0] e, input string req);
    exp_q.push_back(e);
    req_q.push_back(req);
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
    cmd_bit(1'b0);
    for (int i = 0; i < 32; i++) send_bit(1'b0);
    wait_clk(HALF);
    chk(sdo === 1'b1, "R10 idle after read", {31'b0, sdo}, 32'h1);
  endtask

  // monitor
  bit          collecting = 0;
  int          nbits = 0;
  logic [31:0] word;
  always @(posedge sck) begin
    if (!stb_n && !sdi) begin
      collecting = 1; nbits = 0; word = '0;
    end else if (collecting) begin
      word = {word[30:0], sdo};
      nbits++;
      if (nbits == 32) begin
        collecting = 0;
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected read", word, 32'h0);
        else begin
          logic [31:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(word === e, r, word, e);
        end
      end
    end
  end

  // reset pulse monitor
  int run = 0, last_len = 0, n_pulse = 0;
  always @(negedge clk) begin
    if (rreq === 1'b1) run++;
    else if (run != 0) begin
      last_len = run; n_pulse++; run = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    chk(sdo === 1'b1, "R1 sdo after reset", {31'b0, sdo}, 32'h1);
    chk(rreq === 1'b0, "R1 reset req after reset", {31'b0, rreq}, 32'h0);
    do_read(8'h00, 32'h0, "R1 mode reset value");
    do_read(8'h02, 32'h0, "R1 mux reset value");
    do_read(8'h80, 32'h0, "R1 reset reg value");

    do_write(8'h00, 32'h8123_4567);
    do_read(8'h00, 32'h8123_4567, "R2 mode write");
    do_read(8'h00, 32'h8123_4567, "R3 msb-first readback");

    do_write(8'h02, 32'h0F0F_A5A5);
    do_read(8'h02, 32'h0F0F_A5A5, "R4 mux write");
    do_read(8'h00, 32'h8123_4567, "R4 mode untouched");

    sw = 32'h1357_9BDF;
    do_read(8'h08, 32'h1357_9BDF, "R5 switch read");
    do_write(8'h08, 32'hFFFF_0000);
    sw = 32'hC001_0003;
    do_read(8'h08, 32'hC001_0003, "R5 switch read-only");

    do_read(8'hFF, VER, "R6 version");
    do_write(8'hFF, 32'h0);
    do_read(8'hFF, VER, "R6 version read-only");

    do_read(8'h01, 32'h0, "R7 unmapped 0x01");
    do_read(8'h7F, 32'h0, "R7 unmapped 0x7F");
    do_write(8'h01, 32'hDEAD_BEEF);
    do_write(8'h03, 32'hDEAD_BEEF);
    do_read(8'h00, 32'h8123_4567, "R7 mode after unmapped write");
    do_read(8'h02, 32'h0F0F_A5A5, "R7 mux after unmapped write");

    for (int i = 0; i < 9; i++) send_bit(i[0]);
    do_write(8'h00, 32'h0000_00C3);
    do_read(8'h00, 32'h0000_00C3, "R11 stray leading bits");

    do_write(8'h80, 32'hFFFF_FFFE);
    wait_clk(20);
    chk(n_pulse == 0, "R9 no pulse on bit0 clear", n_pulse, 0);

    do_write(8'h80, 32'h0000_0001);
    wait_clk(20);
    chk(n_pulse == 1, "R8 pulse count", n_pulse, 1);
    chk(last_len == RST_CYC, "R8 pulse length", last_len, RST_CYC);
    do_read(8'h80, 32'h0, "R8 reset reg self-clears");
    do_write(8'h80, 32'h0000_0003);
    wait_clk(20);
    chk(n_pulse == 2, "R8 second pulse", n_pulse, 2);
    chk(last_len == RST_CYC, "R8 second length", last_len, RST_CYC);

    wait_clk(10);
    chk(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
    chk(sdo === 1'b1, "R10 final idle", {31'b0, sdo}, 32'h1);
    finish_run();
  end
endmodule